// File: doc/BRIEF.md
# Clock Device Power State Controller

This block sequences the power states of a clock-synthesizer style device. After power is good it waits a programmable number of cycles, asks a configuration loader to copy stored settings into the device registers, starts an oscillator calibration, and then enters normal operation. In normal operation a register bit can hold the output dividers so that they restart counting together. A PLL-reset bit can send the device back through calibration. Power down can be requested by an external pin or by a register bit.

The two power-down requests leave in different ways. Releasing the pin restarts the device from the power-on state, so the configuration is loaded again. Releasing the register bit goes straight to calibration, and the register contents are kept. For each state the block drives an enable for the dividers, the output buffers, the serial port and the PLL. It also drives one-cycle start strobes to the loader and to the calibration engine, and each of these answers with a done level.

Top module: `clkdev_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low the state is power-on (code 0), all four enables are 0 and both start strobes are 0. The state codes are: 0 power-on, 1 calibration, 2 active, 3 power down, 4 divider hold.
- R2: In power-on, `cfg_load_start` pulses for exactly one cycle once `pwr_good` has been high for `POR_DELAY` cycles. The pulse never comes while `pwr_good` is low.
- R3: The block leaves power-on for calibration only when `cfg_load_done` is seen after the load pulse. On every entry to calibration, `cal_start` is high for exactly the first cycle.
- R4: Calibration moves to active without any outside action once `cal_done` is seen after `cal_start`.
- R5: The enables {div_en, buf_en, spi_en, pll_en} follow the state: power-on 0000, calibration 1101, active 1111, power down 0000, divider hold 0111.
- R6: `pd_pin_n` passes through a two-flop synchronizer. When it is low, the state becomes power down 3 clock edges after the pin falls, from any state. This request overrides every other condition.
- R7: When the pin rises after a pin power-down, the state becomes power-on 3 edges later, and the full delay and a new load pulse follow.
- R8: A low `pd_shadow_n` moves calibration, active or divider hold to power down on the next edge. In power-on it is ignored.
- R9: When `pd_shadow_n` rises after a power-down that the shadow bit caused, the state becomes calibration on the next edge, and no load pulse is issued.
- R10: `pll_reset` high in active or divider hold moves the state to calibration on the next edge. It takes priority over the divider-hold request.
- R11: `sync_req_n` low in active enters divider hold on the next edge. `sync_req_n` high in divider hold returns to active on the next edge.
- R12: `pwr_good` low in calibration, active or divider hold returns the state to power-on on the next edge. It ranks below the pin and above the shadow bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pwr_good | input | 1 | Supply is above its threshold |
| pd_pin_n | input | 1 | Asynchronous power-down pin, active low |
| pd_shadow_n | input | 1 | Register power-down bit, active low |
| sync_req_n | input | 1 | Register divider-hold request, active low |
| pll_reset | input | 1 | Register PLL recalibration request |
| cfg_load_done | input | 1 | Configuration loader done level |
| cal_done | input | 1 | Calibration engine done level |
| cfg_load_start | output | 1 | One-cycle strobe that starts a configuration load |
| cal_start | output | 1 | One-cycle strobe that starts a calibration |
| div_en | output | 1 | Output divider enable |
| buf_en | output | 1 | Output buffer enable |
| spi_en | output | 1 | Serial port enable |
| pll_en | output | 1 | PLL enable |
| state_o | output | 3 | Current state code |

## Verification
The hardest case to reach is the difference between the two ways out of power down. The stimulus has to enter power down once through the shadow bit and once through the pin. It must check both the state on the following edges and whether a load strobe appears. The pin case also needs the three-edge synchronizer latency taken into account. To exercise the priority order, the bench holds the pin low while the shadow bit and PLL reset are asserted. It also asserts the shadow bit during power-on, where it must be ignored. A seeded random phase then mixes divider-hold, recalibration and shadow power-down episodes of random length. Throughout that phase the loader must never be restarted.

// File: rtl/clkdev_pwr_pkg.sv
package clkdev_pwr_pkg;

  typedef enum logic [2:0] {
    ST_POR    = 3'd0,
    ST_CAL    = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_PDOWN  = 3'd3,
    ST_SYNC   = 3'd4
  } pwr_state_e;

  typedef struct packed {
    logic div_en;
    logic buf_en;
    logic spi_en;
    logic pll_en;
  } pwr_en_t;

  function automatic pwr_en_t enables_of(pwr_state_e s);
    pwr_en_t e;
    case (s)
      ST_CAL:    e = '{div_en: 1'b1, buf_en: 1'b1, spi_en: 1'b0, pll_en: 1'b1};
      ST_ACTIVE: e = '{div_en: 1'b1, buf_en: 1'b1, spi_en: 1'b1, pll_en: 1'b1};
      ST_SYNC:   e = '{div_en: 1'b0, buf_en: 1'b1, spi_en: 1'b1, pll_en: 1'b1};
      default:   e = '{div_en: 1'b0, buf_en: 1'b0, spi_en: 1'b0, pll_en: 1'b0};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/pwr_bit_sync.sv
module pwr_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d};
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_por_timer.sv
module pwr_por_timer #(
  parameter int DELAY = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int W = $clog2(DELAY + 1);
  localparam logic [W-1:0] LIMIT = W'(DELAY);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign expired = (cnt_q == LIMIT);
  assign cnt_en  = clr || !expired;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import clkdev_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_n_s,
  input  logic       pwr_good,
  input  logic       shadow_n,
  input  logic       sync_n,
  input  logic       pll_reset,
  input  logic       tmr_expired,
  input  logic       load_done,
  input  logic       cal_done,
  output pwr_state_e state_q,
  output logic       tmr_clr,
  output logic       load_start_q,
  output logic       cal_start_q
);
  pwr_state_e nxt;
  logic       pd_by_pin_q;
  logic       load_issued_q;
  logic       fire_load;
  logic       enter_cal;

  // Next state; priority: pin, power loss, shadow, pll reset, divider hold
  always_comb begin
    nxt = state_q;
    if (!pin_n_s) begin
      nxt = ST_PDOWN;
    end else begin
      case (state_q)
        ST_POR: begin
          if (load_issued_q && !load_start_q && load_done) nxt = ST_CAL;
        end
        ST_PDOWN: begin
          if (pd_by_pin_q || !pwr_good) nxt = ST_POR;
          else if (shadow_n)            nxt = ST_CAL;
        end
        default: begin
          if (!pwr_good)                              nxt = ST_POR;
          else if (!shadow_n)                         nxt = ST_PDOWN;
          else if (state_q == ST_CAL) begin
            if (!cal_start_q && cal_done)             nxt = ST_ACTIVE;
          end
          else if (pll_reset)                         nxt = ST_CAL;
          else if (state_q == ST_ACTIVE && !sync_n)   nxt = ST_SYNC;
          else if (state_q == ST_SYNC && sync_n)      nxt = ST_ACTIVE;
          else if (state_q != ST_ACTIVE && state_q != ST_SYNC) nxt = ST_POR;
        end
      endcase
    end
  end

  assign tmr_clr   = (state_q != ST_POR) || !pwr_good;
  assign fire_load = (state_q == ST_POR) && pwr_good && tmr_expired &&
                     !load_issued_q && (nxt == ST_POR);
  assign enter_cal = (nxt == ST_CAL) && (state_q != ST_CAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POR;
    end else begin
      state_q <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_start_q <= 1'b0;
      cal_start_q  <= 1'b0;
    end else begin
      load_start_q <= fire_load;
      cal_start_q  <= enter_cal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_issued_q <= 1'b0;
    end else if (tmr_clr) begin
      load_issued_q <= 1'b0;
    end else if (fire_load) begin
      load_issued_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_by_pin_q <= 1'b0;
    end else if (!pin_n_s) begin
      pd_by_pin_q <= 1'b1;
    end else if (state_q != ST_PDOWN) begin
      pd_by_pin_q <= 1'b0;
    end
  end
endmodule

// File: rtl/clkdev_pwr_ctrl.sv
module clkdev_pwr_ctrl
  import clkdev_pwr_pkg::*;
#(
  parameter int POR_DELAY   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       pd_pin_n,
  input  logic       pd_shadow_n,
  input  logic       sync_req_n,
  input  logic       pll_reset,
  input  logic       cfg_load_done,
  input  logic       cal_done,
  output logic       cfg_load_start,
  output logic       cal_start,
  output logic       div_en,
  output logic       buf_en,
  output logic       spi_en,
  output logic       pll_en,
  output logic [2:0] state_o
);
  logic       rst_core_n;
  logic       pin_n_s;
  logic       tmr_clr;
  logic       tmr_expired;
  pwr_state_e state_q;
  pwr_en_t    en;

  pwr_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_core_n)
  );

  pwr_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (pd_pin_n),
    .q     (pin_n_s)
  );

  pwr_por_timer #(.DELAY(POR_DELAY)) u_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clr     (tmr_clr),
    .expired (tmr_expired)
  );

  pwr_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .pin_n_s      (pin_n_s),
    .pwr_good     (pwr_good),
    .shadow_n     (pd_shadow_n),
    .sync_n       (sync_req_n),
    .pll_reset    (pll_reset),
    .tmr_expired  (tmr_expired),
    .load_done    (cfg_load_done),
    .cal_done     (cal_done),
    .state_q      (state_q),
    .tmr_clr      (tmr_clr),
    .load_start_q (cfg_load_start),
    .cal_start_q  (cal_start)
  );

  assign en      = enables_of(state_q);
  assign div_en  = en.div_en;
  assign buf_en  = en.buf_en;
  assign spi_en  = en.spi_en;
  assign pll_en  = en.pll_en;
  assign state_o = state_q;
endmodule

// File: rtl/clkdev_pwr_ctrl_chk.sv
module clkdev_pwr_ctrl_chk
  import clkdev_pwr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       pin_s,
  input logic       pwr_good,
  input logic       pd_shadow_n,
  input logic       pll_reset,
  input logic       cal_done,
  input logic       cfg_load_start,
  input logic       cal_start,
  input logic       div_en,
  input logic       buf_en,
  input logic       spi_en,
  input logic       pll_en,
  input logic [2:0] state_o
);
  p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd4);

  p_load_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_start |=> !cfg_load_start);

  p_load_in_por_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_start |-> (state_o == ST_POR));

  p_cal_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_CAL && $past(state_o) != ST_CAL) |-> cal_start);

  p_cal_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_ACTIVE && $past(state_o) == ST_CAL) |-> $past(cal_done));

  p_off_states_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_POR || state_o == ST_PDOWN) |-> !(div_en || buf_en || spi_en || pll_en));

  p_active_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_ACTIVE) |-> (div_en && buf_en && spi_en && pll_en));

  p_sync_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_SYNC) |-> (!div_en && buf_en));

  p_pin_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_s |=> (state_o == ST_PDOWN));

  p_pll_recal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_ACTIVE && pll_reset && pin_s && pwr_good && pd_shadow_n)
    |=> (state_o == ST_CAL));
endmodule

bind clkdev_pwr_ctrl clkdev_pwr_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_core_n),
  .pin_s          (pin_n_s),
  .pwr_good       (pwr_good),
  .pd_shadow_n    (pd_shadow_n),
  .pll_reset      (pll_reset),
  .cal_done       (cal_done),
  .cfg_load_start (cfg_load_start),
  .cal_start      (cal_start),
  .div_en         (div_en),
  .buf_en         (buf_en),
  .spi_en         (spi_en),
  .pll_en         (pll_en),
  .state_o        (state_o)
);

// File: tb/tb_clkdev_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_clkdev_pwr_ctrl;
  localparam int DLY = 16;
  localparam int S_POR = 0, S_CAL = 1, S_ACT = 2, S_PD = 3, S_SYN = 4;

  logic clk = 1'b0;
  logic rst_n, pwr_good, pd_pin_n, pd_shadow_n, sync_req_n, pll_reset;
  logic cfg_load_done, cal_done;
  logic cfg_load_start, cal_start, div_en, buf_en, spi_en, pll_en;
  logic [2:0] state_o;

  int n_chk = 0, n_fail = 0;
  int load_cnt = 0, cal_cnt = 0;
  int load_wait = 0, cal_wait = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  clkdev_pwr_ctrl #(.POR_DELAY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pd_pin_n(pd_pin_n),
    .pd_shadow_n(pd_shadow_n), .sync_req_n(sync_req_n), .pll_reset(pll_reset),
    .cfg_load_done(cfg_load_done), .cal_done(cal_done),
    .cfg_load_start(cfg_load_start), .cal_start(cal_start),
    .div_en(div_en), .buf_en(buf_en), .spi_en(spi_en), .pll_en(pll_en),
    .state_o(state_o)
  );

  function automatic logic [3:0] exp_en(int s);
    case (s)
      S_CAL:   return 4'b1101;
      S_ACT:   return 4'b1111;
      S_SYN:   return 4'b0111;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_state(int exp, string req);
    chk(state_o == 3'(exp), req, state_o, exp);
    chk({div_en, buf_en, spi_en, pll_en} == exp_en(exp), "R5",
        {div_en, buf_en, spi_en, pll_en}, exp_en(exp));
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(int exp, string req);
    for (int i = 0; i < 4 * DLY + 40; i++) begin
      if (state_o == 3'(exp)) break;
      tick();
    end
    chk_state(exp, req);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // loader and calibration engine models, plus strobe counters
  initial begin
    cfg_load_done = 1'b0;
    cal_done = 1'b0;
    forever begin
      @(negedge clk);
      if (cfg_load_start) begin
        load_cnt++;
        cfg_load_done = 1'b0;
        load_wait = 1 + int'($urandom % 4);
      end else if (load_wait > 0) begin
        load_wait--;
        if (load_wait == 0) cfg_load_done = 1'b1;
      end
      if (cal_start) begin
        cal_cnt++;
        cal_done = 1'b0;
        cal_wait = 1 + int'($urandom % 5);
      end else if (cal_wait > 0) begin
        cal_wait--;
        if (cal_wait == 0) cal_done = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    int t, lc, cc, op, len;
    void'($urandom(32'h5A17));
    rst_n = 1'b0; pwr_good = 1'b1; pd_pin_n = 1'b1; pd_shadow_n = 1'b1;
    sync_req_n = 1'b1; pll_reset = 1'b0;
    tick(4);
    // R1 reset state
    chk_state(S_POR, "R1");
    chk(!cfg_load_start && !cal_start, "R1", cfg_load_start, 0);
    rst_n = 1'b1;
    // R2 load strobe timing
    t = 0;
    while (!cfg_load_start && t < 4 * DLY) begin tick(); t++; end
    chk(t >= DLY && t <= DLY + 4, "R2", t, DLY + 3);
    tick();
    chk(!cfg_load_start, "R2", cfg_load_start, 0);
    // R3/R4 bring-up
    wait_state(S_CAL, "R3");
    chk(cal_cnt == 1, "R3", cal_cnt, 1);
    wait_state(S_ACT, "R4");
    // R11 divider hold
    sync_req_n = 1'b0; tick();
    chk_state(S_SYN, "R11");
    sync_req_n = 1'b1; tick();
    chk_state(S_ACT, "R11");
    // R10 pll reset beats divider hold request
    cc = cal_cnt;
    pll_reset = 1'b1; sync_req_n = 1'b0; tick();
    pll_reset = 1'b0; sync_req_n = 1'b1;
    chk_state(S_CAL, "R10");
    chk(cal_start == 1'b1, "R3", cal_start, 1);
    wait_state(S_ACT, "R4");
    chk(cal_cnt == cc + 1, "R10", cal_cnt, cc + 1);
    // R8/R9 shadow power down
    lc = load_cnt;
    pd_shadow_n = 1'b0; tick();
    chk_state(S_PD, "R8");
    tick(5);
    chk_state(S_PD, "R8");
    pd_shadow_n = 1'b1; tick();
    chk_state(S_CAL, "R9");
    wait_state(S_ACT, "R9");
    chk(load_cnt == lc, "R9", load_cnt, lc);
    // R6 pin has priority
    pd_pin_n = 1'b0; pd_shadow_n = 1'b0; pll_reset = 1'b1; tick(1);
    pd_shadow_n = 1'b1; pll_reset = 1'b0;
    chk_state(S_PD, "R8");
    tick(2);
    chk_state(S_PD, "R6");
    pll_reset = 1'b1; tick(3);
    pll_reset = 1'b0;
    chk_state(S_PD, "R6");
    // R7 pin release reloads
    pd_pin_n = 1'b1; tick(2);
    chk_state(S_PD, "R6");
    tick();
    chk_state(S_POR, "R7");
    pd_shadow_n = 1'b0; tick(2);
    chk_state(S_POR, "R8");
    pd_shadow_n = 1'b1;
    wait_state(S_ACT, "R7");
    chk(load_cnt == lc + 1, "R7", load_cnt, lc + 1);
    // R12 power loss, R2 no load while low
    pwr_good = 1'b0; tick();
    chk_state(S_POR, "R12");
    tick(3 * DLY);
    chk(load_cnt == lc + 1, "R2", load_cnt, lc + 1);
    chk_state(S_POR, "R12");
    pwr_good = 1'b1;
    wait_state(S_ACT, "R12");
    chk(load_cnt == lc + 2, "R2", load_cnt, lc + 2);
    // random episodes in active
    lc = load_cnt;
    for (int k = 0; k < 40; k++) begin
      op = int'($urandom % 3);
      len = 1 + int'($urandom % 6);
      case (op)
        0: begin
          sync_req_n = 1'b0;
          for (int j = 0; j < len; j++) begin tick(); chk_state(S_SYN, "R11"); end
          sync_req_n = 1'b1; tick();
          chk_state(S_ACT, "R11");
        end
        1: begin
          pll_reset = 1'b1; tick(); pll_reset = 1'b0;
          chk_state(S_CAL, "R10");
          wait_state(S_ACT, "R4");
        end
        default: begin
          pd_shadow_n = 1'b0;
          for (int j = 0; j < len; j++) begin tick(); chk_state(S_PD, "R8"); end
          pd_shadow_n = 1'b1; tick();
          chk_state(S_CAL, "R9");
          wait_state(S_ACT, "R4");
        end
      endcase
    end
    chk(load_cnt == lc, "R9", load_cnt, lc);
    // R1 reset again from active
    rst_n = 1'b0; tick();
    chk_state(S_POR, "R1");
    done_flag = 1;
    finish_run();
  end
endmodule